// File: doc/BRIEF.md
# PCI Target Base Address Registers with Address Hit Decode

This block holds the two base address registers of a PCI target function and compares every bus address against them. Configuration software places the function by writing the registers with type-0 configuration write cycles. It sizes each window by writing all ones and reading the register back. Once a register has been written, the block compares the latched address of each following bus cycle with that register. It pulls the matching active-low hit line low when the command belongs to the window's address space and that space is enabled.

Each register's window size is a 28-bit parameter mask over address bits [31:4]. The mask is ones from bit 31 down to the size boundary and zeros below it. The low nibble of each parameter word holds the constant attribute bits. Bits below the boundary have no storage. They read back as zero, so the usual all-ones sizing write returns the mask. The address compare uses only the bits the mask keeps. The address-space class of each window (I/O or memory) comes from attribute bit 0 of its parameter word.

Top module: `pci_bar_decoder`

## Requirements
- R1: A register write happens at a rising clock edge only when `cmd_lat_n` is 4'b1011 (configuration write), `idsel_lat` is 1 and `irdy_n` is 0. If any of these does not hold, both read-back values stay unchanged.
- R2: The register offset is taken from `addr_lat[7:0]` only: 8'h10 selects register 0 and 8'h14 selects register 1. Any other offset (for example 8'h18 or 8'h0C) writes neither register, and an address of 32'h110 writes register 0.
- R3: In a write, byte lane k (data bits [8k+7:8k]) is stored only when `be_n[k]` is 0. Lanes whose enable is 1 keep their previous contents.
- R4: Each read-back value equals {stored[31:4], 4'hF} ANDed with the register's parameter word, and is updated one clock edge after the write. With the default words, an all-ones write makes `bar0_rd` read 32'hFFF0_0001 (1 MB, I/O) and `bar1_rd` read 32'hFFF0_0000 (1 MB, memory, not prefetchable, anywhere in 32-bit space).
- R5: While `rst_n` is 0, the stored values are zero without waiting for a clock edge. `bar0_rd` then reads 32'h0000_0001 and `bar1_rd` reads 32'h0000_0000.
- R6: A configuration read (`cmd_lat_n` = 4'b1010) never changes a stored value, whatever the address, IDSEL, IRDY# and data.
- R7: `hit0_n` is 0 exactly when register 0 has been written since reset, `cmd_lat_n` is 4'b0010 or 4'b0011 (I/O read or write), `io_space_en` is 1, and `addr_lat[31:4]` equals the stored value on every bit where the size mask is 1. The output follows the inputs combinationally.
- R8: `hit1_n` is 0 exactly when register 1 has been written since reset, `cmd_lat_n` is 4'b0110 or 4'b0111 (memory read or write), `mem_space_en` is 1, and the masked compare with register 1 matches.
- R9: Both hit outputs are 1 during reset and during configuration cycles (command 4'b1010 or 4'b1011). Each is also 1 until its register receives a write with at least one enabled byte lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_lat_n | input | 4 | Command nibble latched in the address phase |
| idsel_lat | input | 1 | Device select for configuration, latched in the address phase |
| irdy_n | input | 1 | Initiator ready, active low |
| addr_lat | input | 32 | Address latched in the address phase |
| be_n | input | 4 | Data-phase byte enables, active low |
| ad_in | input | 32 | Data-phase write data |
| io_space_en | input | 1 | I/O space response enabled by the command register |
| mem_space_en | input | 1 | Memory space response enabled by the command register |
| bar0_rd | output | 32 | Register 0 read-back value |
| bar1_rd | output | 32 | Register 1 read-back value |
| hit0_n | output | 1 | Register 0 window hit, active low |
| hit1_n | output | 1 | Register 1 window hit, active low |

## Verification
A wrong stored bit, a lane written against its byte enable, or a write taken on a disqualified cycle shows on the read-back port at the next clock edge. A lost or spurious written flag, a wrong compare mask or a wrong space class shows on the hit line in the same cycle as the bus access that exercises it. The bench therefore compares both read-back ports before every operation and both hit lines during every operation against a reference model. Addresses are aimed close to the programmed windows so that mask errors in the low bits change the hit result.

// File: rtl/pci_bar_pkg.sv
`timescale 1ns/1ps
package pci_bar_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned ATTR_W = 4;
   localparam int unsigned BASE_W = WORD_W - ATTR_W;
   localparam int unsigned LANES  = WORD_W / 8;

   typedef logic [3:0] cmd_t;

   localparam cmd_t CMD_IO_RD  = 4'b0010;
   localparam cmd_t CMD_IO_WR  = 4'b0011;
   localparam cmd_t CMD_MEM_RD = 4'b0110;
   localparam cmd_t CMD_MEM_WR = 4'b0111;
   localparam cmd_t CMD_CFG_RD = 4'b1010;
   localparam cmd_t CMD_CFG_WR = 4'b1011;

   // size mask must be ones from the top bit down to a boundary, zeros below
   function automatic logic mask_is_contiguous(input logic [BASE_W-1:0] m);
      logic [BASE_W-1:0] inv;
      inv = ~m;
      return ((inv & (inv + 1'b1)) == '0);
   endfunction

   function automatic logic is_io_cmd(input cmd_t c);
      return (c[3:1] == CMD_IO_RD[3:1]);
   endfunction

   function automatic logic is_mem_cmd(input cmd_t c);
      return (c[3:1] == CMD_MEM_RD[3:1]);
   endfunction

endpackage

// File: rtl/bar_cfg_wr_decode.sv
`timescale 1ns/1ps
module bar_cfg_wr_decode
   import pci_bar_pkg::*;
#(
   parameter int unsigned NUM_BARS = 2,
   parameter logic [7:0]  BASE_OFS = 8'h10,
   parameter logic [7:0]  OFS_STEP = 8'h04
) (
   input  cmd_t                cmd,
   input  logic                idsel,
   input  logic                irdy_n,
   input  logic [7:0]          ofs,
   output logic [NUM_BARS-1:0] wr_sel
);

   logic cfg_wr_cycle;
   assign cfg_wr_cycle = (cmd == CMD_CFG_WR) && idsel && !irdy_n;

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_sel
      localparam logic [7:0] MY_OFS = 8'(int'(BASE_OFS) + i * int'(OFS_STEP));
      assign wr_sel[i] = cfg_wr_cycle && (ofs == MY_OFS);
   end

endmodule

// File: rtl/bar_store.sv
`timescale 1ns/1ps
module bar_store
   import pci_bar_pkg::*;
#(
   parameter logic [WORD_W-1:0] WORD = 32'hFFF0_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [LANES-1:0]  be_n,
   input  logic [WORD_W-1:0] wdata,
   output logic [BASE_W-1:0] base,
   output logic              valid,
   output logic [WORD_W-1:0] rd_val
);

   // flops exist only where the size mask keeps an address bit
   for (genvar b = ATTR_W; b < WORD_W; b++) begin : g_bit
      if (WORD[b]) begin : g_ff
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= 1'b0;
            end else if (wr && !be_n[b / 8]) begin
               q <= wdata[b];
            end
         end
         assign base[b - ATTR_W] = q;
      end else begin : g_tie
         assign base[b - ATTR_W] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
      end else if (wr && (be_n != '1)) begin
         valid <= 1'b1;
      end
   end

   assign rd_val = {base, {ATTR_W{1'b1}}} & WORD;

   logic unused_store;
   assign unused_store = ^{wdata, be_n};

endmodule

// File: rtl/bar_hit_cmp.sv
`timescale 1ns/1ps
module bar_hit_cmp
   import pci_bar_pkg::*;
#(
   parameter logic [WORD_W-1:0] WORD = 32'hFFF0_0000
) (
   input  cmd_t              cmd,
   input  logic              io_en,
   input  logic              mem_en,
   input  logic              valid,
   input  logic [BASE_W-1:0] addr_hi,
   input  logic [BASE_W-1:0] base,
   output logic              hit_n
);

   localparam logic [BASE_W-1:0] MASK = WORD[WORD_W-1:ATTR_W];

   logic space_ok;
   logic match;

   if (WORD[0]) begin : g_io
      assign space_ok = is_io_cmd(cmd) && io_en;
   end else begin : g_mem
      assign space_ok = is_mem_cmd(cmd) && mem_en;
   end

   assign match = (((addr_hi ^ base) & MASK) == '0);
   assign hit_n = !(valid && space_ok && match);

   logic unused_cmp;
   assign unused_cmp = ^{cmd, io_en, mem_en};

endmodule

// File: rtl/pci_bar_decoder.sv
`timescale 1ns/1ps
module pci_bar_decoder
   import pci_bar_pkg::*;
#(
   parameter logic [31:0] BAR0_WORD = 32'hFFF0_0001,
   parameter logic [31:0] BAR1_WORD = 32'hFFF0_0000,
   parameter logic [7:0]  BASE_OFS  = 8'h10,
   parameter logic [7:0]  OFS_STEP  = 8'h04
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  cmd_lat_n,
   input  logic        idsel_lat,
   input  logic        irdy_n,
   input  logic [31:0] addr_lat,
   input  logic [3:0]  be_n,
   input  logic [31:0] ad_in,
   input  logic        io_space_en,
   input  logic        mem_space_en,
   output logic [31:0] bar0_rd,
   output logic [31:0] bar1_rd,
   output logic        hit0_n,
   output logic        hit1_n
);

   localparam int unsigned NUM_BARS = 2;
   localparam logic [NUM_BARS-1:0][WORD_W-1:0] WORDS = {BAR1_WORD, BAR0_WORD};

   if (BASE_OFS[1:0] != 2'b00 || OFS_STEP[1:0] != 2'b00) begin : g_bad_ofs
      $error("register offsets must be dword aligned");
   end

   logic [NUM_BARS-1:0]             wr_sel;
   logic [NUM_BARS-1:0][BASE_W-1:0] base;
   logic [NUM_BARS-1:0]             valid;
   logic [NUM_BARS-1:0][WORD_W-1:0] rd_val;
   logic [NUM_BARS-1:0]             hit_n;

   bar_cfg_wr_decode #(
      .NUM_BARS (NUM_BARS),
      .BASE_OFS (BASE_OFS),
      .OFS_STEP (OFS_STEP)
   ) i_wr_decode (
      .cmd    (cmd_lat_n),
      .idsel  (idsel_lat),
      .irdy_n (irdy_n),
      .ofs    (addr_lat[7:0]),
      .wr_sel (wr_sel)
   );

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      if (!mask_is_contiguous(WORDS[i][WORD_W-1:ATTR_W])) begin : g_bad_mask
         $error("size mask is not contiguous from the top bit");
      end
      if (WORDS[i][0] && WORDS[i][3]) begin : g_bad_attr
         $error("an I/O window cannot be prefetchable");
      end

      bar_store #(
         .WORD (WORDS[i])
      ) i_store (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (wr_sel[i]),
         .be_n   (be_n),
         .wdata  (ad_in),
         .base   (base[i]),
         .valid  (valid[i]),
         .rd_val (rd_val[i])
      );

      bar_hit_cmp #(
         .WORD (WORDS[i])
      ) i_hit (
         .cmd     (cmd_lat_n),
         .io_en   (io_space_en),
         .mem_en  (mem_space_en),
         .valid   (valid[i]),
         .addr_hi (addr_lat[WORD_W-1:ATTR_W]),
         .base    (base[i]),
         .hit_n   (hit_n[i])
      );
   end

   assign bar0_rd = rd_val[0];
   assign bar1_rd = rd_val[1];
   assign hit0_n  = hit_n[0];
   assign hit1_n  = hit_n[1];

endmodule

// File: rtl/pci_bar_decoder_chk.sv
`timescale 1ns/1ps
module pci_bar_decoder_chk
   import pci_bar_pkg::*;
#(
   parameter logic [31:0] BAR0_WORD = 32'hFFF0_0001,
   parameter logic [31:0] BAR1_WORD = 32'hFFF0_0000,
   parameter logic [7:0]  BASE_OFS  = 8'h10
) (
   input logic        clk,
   input logic        rst_n,
   input logic [3:0]  cmd_lat_n,
   input logic        idsel_lat,
   input logic        irdy_n,
   input logic [31:0] addr_lat,
   input logic [3:0]  be_n,
   input logic        io_space_en,
   input logic        mem_space_en,
   input logic [31:0] bar0_rd,
   input logic [31:0] bar1_rd,
   input logic        hit0_n,
   input logic        hit1_n
);

   logic qual_wr;
   assign qual_wr = (cmd_lat_n == CMD_CFG_WR) && idsel_lat && !irdy_n;

   assert_no_stray_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !qual_wr |=> ($stable(bar0_rd) && $stable(bar1_rd)));

   assert_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_wr && addr_lat[7:0] == BASE_OFS && be_n[3]) |=> $stable(bar0_rd[31:24]));

   assert_attr_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bar0_rd[3:0] == BAR0_WORD[3:0]) && (bar1_rd[3:0] == BAR1_WORD[3:0]));

   assert_cfg_read_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_lat_n == CMD_CFG_RD) |=> ($stable(bar0_rd) && $stable(bar1_rd)));

   assert_hit0_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit0_n |-> (BAR0_WORD[0] ? (is_io_cmd(cmd_lat_n) && io_space_en)
                                : (is_mem_cmd(cmd_lat_n) && mem_space_en)));

   assert_hit1_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit1_n |-> (BAR1_WORD[0] ? (is_io_cmd(cmd_lat_n) && io_space_en)
                                : (is_mem_cmd(cmd_lat_n) && mem_space_en)));

   assert_cfg_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_lat_n[3:1] == CMD_CFG_RD[3:1]) |-> (hit0_n && hit1_n));

endmodule

bind pci_bar_decoder pci_bar_decoder_chk #(
   .BAR0_WORD (BAR0_WORD),
   .BAR1_WORD (BAR1_WORD),
   .BASE_OFS  (BASE_OFS)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_lat_n    (cmd_lat_n),
   .idsel_lat    (idsel_lat),
   .irdy_n       (irdy_n),
   .addr_lat     (addr_lat),
   .be_n         (be_n),
   .io_space_en  (io_space_en),
   .mem_space_en (mem_space_en),
   .bar0_rd      (bar0_rd),
   .bar1_rd      (bar1_rd),
   .hit0_n       (hit0_n),
   .hit1_n       (hit1_n)
);

// File: tb/test_pci_bar_decoder.sv
`timescale 1ns/1ps
module test_pci_bar_decoder;

   localparam logic [31:0] W0 = 32'hFFF0_0001;
   localparam logic [31:0] W1 = 32'hFFF0_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cmd_lat_n = 4'h0;
   logic        idsel_lat = 1'b0;
   logic        irdy_n = 1'b1;
   logic [31:0] addr_lat = '0;
   logic [3:0]  be_n = 4'hF;
   logic [31:0] ad_in = '0;
   logic        io_space_en = 1'b0;
   logic        mem_space_en = 1'b0;
   logic [31:0] bar0_rd, bar1_rd;
   logic        hit0_n, hit1_n;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [31:0] m_st [2];
   bit          m_val [2];

   always #2 clk = ~clk;

   pci_bar_decoder i_pci_bar_decoder (
      .clk (clk), .rst_n (rst_n), .cmd_lat_n (cmd_lat_n), .idsel_lat (idsel_lat),
      .irdy_n (irdy_n), .addr_lat (addr_lat), .be_n (be_n), .ad_in (ad_in),
      .io_space_en (io_space_en), .mem_space_en (mem_space_en),
      .bar0_rd (bar0_rd), .bar1_rd (bar1_rd), .hit0_n (hit0_n), .hit1_n (hit1_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input int i);
      return {m_st[i][31:4], 4'hF} & (i == 0 ? W0 : W1);
   endfunction

   function automatic logic exp_hit_n(input int i);
      logic [31:0] w;
      logic sp;
      w  = (i == 0) ? W0 : W1;
      sp = (i == 0) ? ((cmd_lat_n == 4'b0010 || cmd_lat_n == 4'b0011) && io_space_en)
                    : ((cmd_lat_n == 4'b0110 || cmd_lat_n == 4'b0111) && mem_space_en);
      return !(m_val[i] && sp && (((addr_lat[31:4] ^ m_st[i][31:4]) & w[31:4]) == '0));
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 2; i++) begin
         m_st[i]  = '0;
         m_val[i] = 0;
      end
   endtask

   // one bus cycle: read-backs checked before driving, hits checked while driven
   task automatic bus_op(input logic [3:0] c, input logic ids, input logic irdy,
                         input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                         input logic ioe, input logic meme, input string htag);
      int idx;
      @(negedge clk);
      chk("R4 bar0 read-back", bar0_rd, exp_rd(0));
      chk("R4 bar1 read-back", bar1_rd, exp_rd(1));
      cmd_lat_n = c; idsel_lat = ids; irdy_n = irdy; addr_lat = a;
      ad_in = d; be_n = be; io_space_en = ioe; mem_space_en = meme;
      #1;
      chk({htag, " hit0"}, {31'b0, hit0_n}, {31'b0, exp_hit_n(0)});
      chk({htag, " hit1"}, {31'b0, hit1_n}, {31'b0, exp_hit_n(1)});
      @(posedge clk);
      idx = (a[7:0] == 8'h10) ? 0 : (a[7:0] == 8'h14) ? 1 : -1;
      if (c == 4'b1011 && ids && !irdy && idx >= 0) begin
         for (int j = 0; j < 4; j++)
            if (!be[j]) m_st[idx][8*j +: 8] = d[8*j +: 8];
         if (be != 4'hF) m_val[idx] = 1;
      end
   endtask

   task automatic cfg_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
      bus_op(4'b1011, 1'b1, 1'b0, a, d, be, 1'b1, 1'b1, "R9 cfg write");
   endtask

   task automatic settle_check(input string tag, input logic [31:0] e0, input logic [31:0] e1);
      @(negedge clk);
      cmd_lat_n = 4'h0; irdy_n = 1'b1;
      #1;
      chk({tag, " bar0"}, bar0_rd, e0);
      chk({tag, " bar1"}, bar1_rd, e1);
   endtask

   task automatic reset_pulse();
      @(negedge clk);
      rst_n = 1'b0;
      cmd_lat_n = 4'b0010; io_space_en = 1'b1; mem_space_en = 1'b1;
      addr_lat = m_st[0];
      #1;
      chk("R5 reset bar0", bar0_rd, 32'h0000_0001);
      chk("R5 reset bar1", bar1_rd, 32'h0000_0000);
      chk("R9 reset hit0", {31'b0, hit0_n}, 32'd1);
      cmd_lat_n = 4'b0110; addr_lat = m_st[1];
      #1;
      chk("R9 reset hit1", {31'b0, hit1_n}, 32'd1);
      model_clear();
      @(negedge clk);
      rst_n = 1'b1;
      cmd_lat_n = 4'h0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [3:0] cmds [8] = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'h0, 4'hF};
      logic [7:0] ofss [6] = '{8'h10, 8'h14, 8'h18, 8'h0C, 8'h10, 8'h14};
      void'($urandom(32'd20240611));
      model_clear();
      repeat (3) @(posedge clk);
      reset_pulse();

      // R9: no hit before any write
      bus_op(4'b0010, 1'b0, 1'b0, 32'h0000_0000, '0, 4'h0, 1'b1, 1'b1, "R9 unwritten");
      bus_op(4'b0110, 1'b0, 1'b0, 32'h0000_0000, '0, 4'h0, 1'b1, 1'b1, "R9 unwritten");

      // R4: sizing
      cfg_wr(32'h10, 32'hFFFF_FFFF, 4'h0);
      cfg_wr(32'h14, 32'hFFFF_FFFF, 4'h0);
      settle_check("R4 sizing", 32'hFFF0_0001, 32'hFFF0_0000);

      // program and hit
      cfg_wr(32'h10, 32'h1234_5678, 4'h0);
      cfg_wr(32'h14, 32'hA550_0000, 4'h0);
      settle_check("R4 programmed", 32'h1230_0001, 32'hA550_0000);
      bus_op(4'b0010, 1'b0, 1'b0, 32'h123A_BCDE, '0, 4'hF, 1'b1, 1'b0, "R7 io hit");
      chk("R7 io hit low", {31'b0, hit0_n}, 32'd0);
      bus_op(4'b0011, 1'b0, 1'b0, 32'h123A_BCDE, '0, 4'hF, 1'b0, 1'b1, "R7 io disabled");
      bus_op(4'b0110, 1'b0, 1'b0, 32'h123A_BCDE, '0, 4'hF, 1'b1, 1'b1, "R7 wrong space");
      bus_op(4'b0011, 1'b0, 1'b0, 32'h1240_0000, '0, 4'hF, 1'b1, 1'b1, "R7 outside");
      bus_op(4'b0111, 1'b0, 1'b0, 32'hA55F_0000, '0, 4'hF, 1'b0, 1'b1, "R8 mem hit");
      chk("R8 mem hit low", {31'b0, hit1_n}, 32'd0);
      bus_op(4'b0010, 1'b0, 1'b0, 32'hA55F_0000, '0, 4'hF, 1'b1, 1'b1, "R8 wrong space");
      bus_op(4'b1011, 1'b1, 1'b1, 32'hA550_0014, '0, 4'hF, 1'b1, 1'b1, "R9 cfg cycle");

      // R1: disqualified writes
      bus_op(4'b1011, 1'b1, 1'b1, 32'h10, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b1, "R1 irdy high");
      bus_op(4'b1011, 1'b0, 1'b0, 32'h10, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b1, "R1 idsel low");
      settle_check("R1 no write", 32'h1230_0001, 32'hA550_0000);
      // R6: config read
      bus_op(4'b1010, 1'b1, 1'b0, 32'h14, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b1, "R6 cfg read");
      settle_check("R6 cfg read", 32'h1230_0001, 32'hA550_0000);
      // R2: offsets
      cfg_wr(32'h18, 32'hFFFF_FFFF, 4'h0);
      cfg_wr(32'h0C, 32'hFFFF_FFFF, 4'h0);
      settle_check("R2 other offset", 32'h1230_0001, 32'hA550_0000);
      cfg_wr(32'h110, 32'h7770_0000, 4'h0);
      settle_check("R2 alias", 32'h7770_0001, 32'hA550_0000);
      // R3: lanes
      cfg_wr(32'h10, 32'hDEAD_BEEF, 4'b0111);
      settle_check("R3 top lane", 32'hDE70_0001, 32'hA550_0000);
      cfg_wr(32'h14, 32'hFFFF_FFFF, 4'b1011);
      settle_check("R3 lane 2", 32'hDE70_0001, 32'hA5F0_0000);

      reset_pulse();

      // random mix
      for (int n = 0; n < 600; n++) begin
         int kind = $urandom_range(0, 2);
         logic [31:0] a;
         if (kind == 0) begin
            a = {$urandom_range(0, 15) == 0 ? 24'h000001 : 24'h0, ofss[$urandom_range(0, 5)]};
            bus_op(4'b1011, $urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0,
                   a, $urandom, 4'($urandom), 1'b1, 1'b1, "R1 random write");
         end else begin
            int t = $urandom_range(0, 1);
            a = $urandom;
            if ($urandom_range(0, 1) == 1) a = {m_st[t][31:12], a[11:0]};
            bus_op(cmds[$urandom_range(0, 7)], 1'($urandom), 1'($urandom), a, $urandom,
                   4'($urandom), 1'($urandom), 1'($urandom), t == 0 ? "R7 random" : "R8 random");
         end
      end
      @(negedge clk);
      chk("R4 final bar0", bar0_rd, exp_rd(0));
      chk("R4 final bar1", bar1_rd, exp_rd(1));

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule